// File: doc/BRIEF.md
# Bidirectional Parallel Port with Chip-Select Takeover

This block is an eight-line parallel I/O port controlled over a small memory-mapped register bus. Each line has a data bit and a direction bit. A line set as an output drives its latched value. A line set as an input is sampled through a two-stage synchronizer, and the sampled level is what software reads. One option bit changes the whole port from push-pull to open-drain signalling.

In an expanded bus mode, the upper four lines can serve as active-low chip-select outputs. The address decoders sit outside this block and arrive as four strobe inputs. Each chip-select line has its own enable bit. A line whose enable bit is clear, or any upper line while the expanded mode is off, stays an ordinary I/O line. Tri-state resolution happens outside the block, so each line is presented as a separate output value, output enable and input.

Top module: `gpio_cs_port`

## Requirements
- R1: The register address is `bus_addr`. Address 0 is the data register, address 1 the direction register and address 2 the option register. In the option register, bit 0 is the open-drain select, bits 7:4 are the chip-select enables for pins 7:4 (bit 4+j enables strobe j), and bits 3:1 read back as 0. Address 3 reads as 0. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. `bus_rdata` is combinational on `bus_addr`.
- R2: Reset clears the direction and option registers, so every `pin_oe` bit is 0 after reset.
- R3: Reset does not clear the data latch. While reset is held, the latch loads the synchronized pin levels, so after reset it holds the levels that were present on the pins.
- R4: With open-drain off and no chip-select takeover, a pin with direction bit 1 has `pin_oe`=1 and `pin_out` equal to its latch bit. A pin with direction bit 0 has `pin_oe`=0.
- R5: A read of address 0 returns the latch bit for output pins and the synchronized pin level for input pins.
- R6: A write to address 0 updates all eight latch bits, including those of input pins. The value appears on a pin once that pin becomes an output.
- R7: A pin level change is visible in a data read after exactly two rising clock edges.
- R8: When `mode_expanded` is 1 and the enable for strobe j is set, pin 4+j is forced to be an output and drives `cs_n[j]`, whatever its direction bit and latch hold.
- R9: An upper pin whose enable is clear, or any upper pin while `mode_expanded` is 0, behaves as in R4.
- R10: With open-drain on, `pin_out` is all zeros. A pin that would otherwise drive a 0 has `pin_oe`=1, and a pin that would drive a 1 has `pin_oe`=0. This applies to chip-select pins as well.
- R11: A read of address 1 returns the direction register last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| mode_expanded | input | 1 | Expanded bus mode, allows chip-select takeover |
| cs_n | input | 4 | Active-low chip-select strobes from external decoders |
| pin_in | input | 8 | Pin levels seen from the pads |
| pin_out | output | 8 | Value driven to the pads |
| pin_oe | output | 8 | Pad output enables |

## Verification
The synchronizer assertion assumes that `pin_in` is defined throughout reset, because the latch captures the synchronized level there. The bench therefore drives a known pattern onto the pins from time zero and holds reset for five cycles. The write assertions assume that `bus_wdata` and `bus_addr` are stable at the sampling edge. The bench changes all bus and strobe inputs only at falling edges. It also keeps the pins static during the register sweeps, so that a read compares against a settled synchronizer.

// File: rtl/gpio_cs_pkg.sv
package gpio_cs_pkg;

    parameter int PORT_W = 8;
    parameter int CS_W   = 4;
    parameter int ADDR_W = 2;

    localparam int CS_BASE = PORT_W - CS_W;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_OPT  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [CS_W-1:0] cs_en;
        logic            open_drain;
    } opt_t;

    typedef struct packed {
        logic oe;
        logic val;
    } pad_drv_t;

    function automatic logic [PORT_W-1:0] opt_to_word(opt_t o);
        logic [PORT_W-1:0] w;
        w = '0;
        w[PORT_W-1 -: CS_W] = o.cs_en;
        w[0] = o.open_drain;
        return w;
    endfunction

    function automatic opt_t word_to_opt(logic [PORT_W-1:0] w);
        opt_t o;
        o.cs_en = w[PORT_W-1 -: CS_W];
        o.open_drain = w[0];
        return o;
    endfunction

    // Turns a drive request into pad signals for push-pull or open-drain.
    function automatic pad_drv_t shape_drive(logic drive, logic level, logic od);
        pad_drv_t p;
        if (od) begin
            p.oe  = drive & ~level;
            p.val = 1'b0;
        end else begin
            p.oe  = drive;
            p.val = level;
        end
        return p;
    endfunction

endpackage

// File: rtl/gpio_cs_sync.sv
module gpio_cs_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_q
);
    logic [W-1:0] stage1;

    // Data flops carry no reset so that they keep sampling during reset.
    always_ff @(posedge clk) begin
        stage1 <= async_in;
        sync_q <= stage1;
    end

    assert_sync_delay_R7: assert property (@(posedge clk) disable iff (rst)
        sync_q == $past(async_in, 2));

endmodule

// File: rtl/gpio_cs_regs.sv
module gpio_cs_regs
    import gpio_cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    input  logic [PORT_W-1:0] pin_sync,
    output logic [PORT_W-1:0] bus_rdata,
    output logic [PORT_W-1:0] data_q,
    output logic [PORT_W-1:0] dir_q,
    output opt_t              opt_q
);
    reg_sel_e sel_reg;
    logic     wr_data, wr_dir, wr_opt;
    logic     unused_wbits;

    assign sel_reg = reg_sel_e'(bus_addr);
    assign wr_data = bus_sel && bus_wr && (sel_reg == REG_DATA);
    assign wr_dir  = bus_sel && bus_wr && (sel_reg == REG_DIR);
    assign wr_opt  = bus_sel && bus_wr && (sel_reg == REG_OPT);
    assign unused_wbits = ^bus_wdata[CS_BASE-1:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            opt_q <= '0;
        end else begin
            if (wr_dir) dir_q <= bus_wdata;
            if (wr_opt) opt_q <= word_to_opt(bus_wdata);
        end
    end

    // Latch has no reset value; it follows the pins while reset is held.
    always_ff @(posedge clk) begin
        if (rst)          data_q <= pin_sync;
        else if (wr_data) data_q <= bus_wdata;
    end

    always_comb begin
        unique case (sel_reg)
            REG_DATA: bus_rdata = (dir_q & data_q) | (~dir_q & pin_sync);
            REG_DIR:  bus_rdata = dir_q;
            REG_OPT:  bus_rdata = opt_to_word(opt_q);
            default:  bus_rdata = '0;
        endcase
    end

    assert_ctrl_reset_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (dir_q == '0 && opt_q == '0));

    assert_latch_write_R6: assert property (@(posedge clk) disable iff (rst)
        wr_data |=> (data_q == $past(bus_wdata)));

    assert_dir_write_R11: assert property (@(posedge clk) disable iff (rst)
        wr_dir |=> (dir_q == $past(bus_wdata)));

    assert_latch_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_data |=> $stable(data_q));

endmodule

// File: rtl/gpio_cs_pinmux.sv
module gpio_cs_pinmux
    import gpio_cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] data_q,
    input  logic [PORT_W-1:0] dir_q,
    input  opt_t              opt_q,
    input  logic              mode_expanded,
    input  logic [CS_W-1:0]   cs_n,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);
    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        logic     cs_take;
        logic     level;
        pad_drv_t pad;

        if (i >= CS_BASE) begin : g_cs
            assign cs_take = mode_expanded & opt_q.cs_en[i-CS_BASE];
            assign level   = cs_take ? cs_n[i-CS_BASE] : data_q[i];

            assert_cs_take_R8: assert property (@(posedge clk) disable iff (rst)
                (cs_take && !opt_q.open_drain) |->
                    (pin_oe[i] && pin_out[i] == cs_n[i-CS_BASE]));

            assert_cs_idle_R9: assert property (@(posedge clk) disable iff (rst)
                (!(mode_expanded && opt_q.cs_en[i-CS_BASE]) && !opt_q.open_drain) |->
                    (pin_oe[i] == dir_q[i]));
        end else begin : g_gp
            assign cs_take = 1'b0;
            assign level   = data_q[i];
        end

        assign pad        = shape_drive(cs_take | dir_q[i], level, opt_q.open_drain);
        assign pin_oe[i]  = pad.oe;
        assign pin_out[i] = pad.val;
    end

    assert_od_low_only_R10: assert property (@(posedge clk) disable iff (rst)
        opt_q.open_drain |-> (pin_out == '0));

endmodule

// File: rtl/gpio_cs_port.sv
module gpio_cs_port
    import gpio_cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic              mode_expanded,
    input  logic [CS_W-1:0]   cs_n,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);
    logic [PORT_W-1:0] pin_sync;
    logic [PORT_W-1:0] data_q;
    logic [PORT_W-1:0] dir_q;
    opt_t              opt_q;

    gpio_cs_sync #(.W(PORT_W)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_q   (pin_sync)
    );

    gpio_cs_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pin_sync  (pin_sync),
        .bus_rdata (bus_rdata),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .opt_q     (opt_q)
    );

    gpio_cs_pinmux u_mux (
        .clk           (clk),
        .rst           (rst),
        .data_q        (data_q),
        .dir_q         (dir_q),
        .opt_q         (opt_q),
        .mode_expanded (mode_expanded),
        .cs_n          (cs_n),
        .pin_out       (pin_out),
        .pin_oe        (pin_oe)
    );

    assert_oe_after_reset_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pin_oe == '0));

    assert_plain_gpio_R4: assert property (@(posedge clk) disable iff (rst)
        (!mode_expanded && !opt_q.open_drain) |-> (pin_oe == dir_q && (pin_out & dir_q) == (data_q & dir_q)));

endmodule

// File: tb/gpio_cs_port_test.sv
module gpio_cs_port_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       mode_expanded = 1'b0;
    logic [3:0] cs_n = 4'hF;
    logic [7:0] pin_in = 8'hA5;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    gpio_cs_port uut (
        .clk           (clk),
        .rst           (rst),
        .bus_sel       (bus_sel),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .mode_expanded (mode_expanded),
        .cs_n          (cs_n),
        .pin_in        (pin_in),
        .pin_out       (pin_out),
        .pin_oe        (pin_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Expected pad signals from the requirement text (R4, R8, R9, R10).
    task automatic expect_pads(input logic [7:0] lat, input logic [7:0] dir,
                               input logic [7:0] opt, input logic ex,
                               input logic [3:0] csn,
                               output logic [7:0] eo, output logic [7:0] ee);
        for (int i = 0; i < 8; i++) begin
            logic take, drv, v;
            take = (i >= 4) && ex && opt[i];
            drv  = take || dir[i];
            v    = take ? csn[i-4] : lat[i];
            if (opt[0]) begin
                ee[i] = drv && !v;
                eo[i] = 1'b0;
            end else begin
                ee[i] = drv;
                eo[i] = v;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, eo, ee;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        #1;

        // R2: reset state
        chk("R2 oe", pin_oe, 8'h00);
        rd(2'd1, r); chk("R2 dir", r, 8'h00);
        rd(2'd2, r); chk("R2 opt", r, 8'h00);

        // R3: latch holds the pin pattern seen during reset
        wr(2'd1, 8'hFF);
        chk("R3 out", pin_out, 8'hA5);
        chk("R4 oe all", pin_oe, 8'hFF);
        rd(2'd0, r); chk("R3 read", r, 8'hA5);
        wr(2'd1, 8'h00);
        chk("R4 oe none", pin_oe, 8'h00);

        // R7: two-edge synchronizer latency
        @(negedge clk);
        pin_in = 8'h3C;
        bus_addr = 2'd0;
        @(negedge clk); #1;
        chk("R7 one edge", bus_rdata, 8'hA5);
        @(negedge clk); #1;
        chk("R7 two edges", bus_rdata, 8'h3C);

        // R6: write to latch while all pins are inputs
        wr(2'd0, 8'h5A);
        rd(2'd0, r); chk("R6 input read", r, 8'h3C);
        wr(2'd1, 8'hFF);
        chk("R6 appears", pin_out, 8'h5A);
        rd(2'd0, r); chk("R6 read", r, 8'h5A);

        // R5, R4, R11: sweep every direction pattern
        @(negedge clk);
        pin_in = 8'hC3;
        repeat (3) @(negedge clk);
        for (int d = 0; d < 256; d++) begin
            wr(2'd1, d[7:0]);
            rd(2'd1, r); chk("R11 dir read", r, d[7:0]);
            rd(2'd0, r); chk("R5 mixed read", r, (d[7:0] & 8'h5A) | (~d[7:0] & 8'hC3));
            chk("R4 oe", pin_oe, d[7:0]);
            chk("R4 out", pin_out & d[7:0], 8'h5A & d[7:0]);
        end

        // R1: register map corners
        wr(2'd2, 8'hFF);
        rd(2'd2, r); chk("R1 opt reserved", r, 8'hF1);
        rd(2'd3, r); chk("R1 unused addr", r, 8'h00);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd1; bus_wdata = 8'h00;
        @(negedge clk); bus_sel = 1'b0; #1;
        rd(2'd1, r); chk("R1 no write without wr", r, 8'hFF);

        // R8, R9, R10: sweep options, mode and strobes
        wr(2'd1, 8'h33);
        wr(2'd0, 8'h96);
        for (int od = 0; od < 2; od++) begin
            for (int en = 0; en < 16; en++) begin
                logic [7:0] opt;
                opt = {en[3:0], 3'b000, od[0]};
                wr(2'd2, opt);
                for (int ex = 0; ex < 2; ex++) begin
                    for (int c = 0; c < 16; c++) begin
                        @(negedge clk);
                        mode_expanded = ex[0];
                        cs_n = c[3:0];
                        #1;
                        expect_pads(8'h96, 8'h33, opt, ex[0], c[3:0], eo, ee);
                        if (od != 0) begin
                            chk("R10 oe", pin_oe, ee);
                            chk("R10 out", pin_out, eo);
                        end else if (ex != 0 && en != 0) begin
                            chk("R8 oe", pin_oe, ee);
                            chk("R8 out", pin_out & ee, eo & ee);
                        end else begin
                            chk("R9 oe", pin_oe, ee);
                            chk("R9 out", pin_out & ee, eo & ee);
                        end
                    end
                end
            end
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule